// File: doc/BRIEF.md
# Nibble-Aligned Variable Codeword Decoder

This block turns a densely packed instruction stream back into full 32-bit instructions. The stream is a run of items that sit on 4-bit boundaries with no padding between them. Each item is either a short codeword that selects a dictionary entry or an escaped raw instruction. Memory words of 32 bits enter a nibble shift buffer. The decoder reads the leading nibble of the oldest item, works out the length of the item, and waits until the whole item is buffered. For a codeword it then drives a dictionary index and issues the one to four instructions of that entry on consecutive cycles. For an escape it issues the 32 bits that follow the escape nibble.

Each decoded item also reports how many nibbles it used, so the fetch logic can advance its nibble pointer. A redirect discards everything buffered and any expansion in progress. The next memory word is then read from a given nibble offset, which lets a branch land inside a word. The dictionary itself sits outside the block and is read combinationally.

Top module: `nibble_cw_decoder`

## Requirements
- R1: After reset the buffer is empty, no instruction and no consumed count are valid, and `word_ready_o` is high.
- R2: Nibbles are taken from each word most significant first, starting at bits 31:28. Items follow one another with no gap and may cross word boundaries.
- R3: The leading nibble alone sets the item length. Values 0x0 to 0x7 give 2 nibbles, 0x8 to 0xC give 3, 0xD and 0xE give 4, and 0xF gives 9. This length appears on `consumed_o` with `consumed_valid_o` in the cycle the item is decoded.
- R4: The dictionary index for an 8-bit code is its low 7 bits (0 to 127). For a 12-bit code it is 128 + (code - 0x800), giving 128 to 1407. For a 16-bit code it is 1408 + (code - 0xD000), giving 1408 to 9599.
- R5: For a leading nibble of 0xF, `instr_o` carries the next 8 nibbles as one instruction, with the first of them in bits 31:28. No dictionary entry is used.
- R6: A dictionary entry holds `dict_len_i`+1 instructions, with instruction 0 in `dict_entry_i[127:96]` and the rest below it in order. Instruction 0 is issued in the decode cycle and each of the others in one following cycle. No new item is decoded until the last instruction has been issued.
- R7: An item is not decoded and no output is valid until all of its nibbles are in the buffer.
- R8: A word is taken only when `word_valid_i` and `word_ready_o` are both high. `word_ready_o` is high only while at most BUF_NIB-8 nibbles are buffered, so no data is lost.
- R9: `redirect_i` empties the buffer and stops any expansion. The first `redirect_nib_i` nibbles of the next word taken are then dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_valid_i | input | 1 | Memory word offered |
| word_i | input | 32 | Memory word, first nibble in bits 31:28 |
| word_ready_o | output | 1 | Buffer can take a word |
| redirect_i | input | 1 | Flush and restart the stream |
| redirect_nib_i | input | 3 | Nibbles to drop from the next word |
| dict_idx_o | output | 14 | Dictionary index of the item being decoded |
| dict_rd_o | output | 1 | Codeword decoded this cycle |
| dict_entry_i | input | 128 | Entry read at dict_idx_o, instruction 0 in the top bits |
| dict_len_i | input | 2 | Instructions in the entry minus one |
| instr_valid_o | output | 1 | Instruction issued |
| instr_o | output | 32 | Issued instruction |
| consumed_valid_o | output | 1 | Item decoded this cycle |
| consumed_o | output | 4 | Nibbles used by the item |

## Verification
A wrong nibble count, or a bad shift in the buffer, puts every later item out of frame. It shows up on the next decode cycle as a wrong length on `consumed_o` or as a wrong instruction, and garbage follows from then on. A fault in the expansion counter adds, drops or reorders instructions within an entry, which the scoreboard sees in the very next cycle. The same cycle-exact comparison exposes a wrong skip after a redirect or a stall that is ignored: the first item then decodes early or with the wrong content.

// File: rtl/nibdec_pkg.sv
package nibdec_pkg;
  parameter int unsigned NIB_W     = 4;
  parameter int unsigned INSTR_W   = 32;
  parameter int unsigned ENTRY_MAX = 4;
  parameter int unsigned IDX_W     = 14;
  parameter int unsigned LEN_W     = $clog2(ENTRY_MAX);
  parameter int unsigned ENTRY_W   = ENTRY_MAX * INSTR_W;
  parameter int unsigned HEAD_NIB  = 1 + INSTR_W / NIB_W;
  parameter int unsigned IDX_BASE12 = 128;
  parameter int unsigned IDX_BASE16 = 1408;
  parameter int unsigned IDX_LIMIT  = 9600;

  typedef enum logic [1:0] {K_CW8, K_CW12, K_CW16, K_ESC} item_kind_e;
endpackage

// File: rtl/nibdec_classify.sv
module nibdec_classify
  import nibdec_pkg::*;
(
  input  logic [4*NIB_W-1:0] lead_i,
  output item_kind_e         kind_o,
  output logic [3:0]         need_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [3:0] lead;
  assign lead = lead_i[4*NIB_W-1 -: 4];

  always_comb begin
    kind_o = K_ESC;
    need_o = 4'(HEAD_NIB);
    idx_o  = '0;
    if (lead < 4'h8) begin
      kind_o = K_CW8;
      need_o = 4'd2;
      idx_o  = IDX_W'(lead_i[14:8]);
    end else if (lead < 4'hD) begin
      kind_o = K_CW12;
      need_o = 4'd3;
      idx_o  = IDX_W'(IDX_BASE12) + IDX_W'({lead[2:0], lead_i[11:4]});
    end else if (lead != 4'hF) begin
      kind_o = K_CW16;
      need_o = 4'd4;
      idx_o  = IDX_W'(IDX_BASE16) + IDX_W'({lead[1], lead_i[11:0]});
    end
  end
endmodule

// File: rtl/nibdec_buffer.sv
module nibdec_buffer
  import nibdec_pkg::*;
#(
  parameter int unsigned BUF_NIB = 20,
  localparam int unsigned BUF_BITS = BUF_NIB * NIB_W,
  localparam int unsigned CNT_W    = $clog2(BUF_NIB + 1),
  localparam int unsigned WNIB     = INSTR_W / NIB_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        push_i,
  input  logic [INSTR_W-1:0]          word_i,
  input  logic [3:0]                  take_i,
  input  logic                        flush_i,
  input  logic [2:0]                  flush_nib_i,
  output logic [HEAD_NIB*NIB_W-1:0]   head_o,
  output logic [CNT_W-1:0]            cnt_o,
  output logic                        room_o
);
  logic [BUF_BITS-1:0] buf_q, shifted, app;
  logic [CNT_W-1:0]    cnt_q, base, add;
  logic [2:0]          skip_q;
  logic [INSTR_W-1:0]  wsh;

  always_comb begin
    shifted = buf_q << (NIB_W * take_i);
    base    = cnt_q - CNT_W'(take_i);
    wsh     = word_i << (NIB_W * skip_q);
    add     = CNT_W'(WNIB) - CNT_W'(skip_q);
    app     = {wsh, {(BUF_BITS-INSTR_W){1'b0}}} >> (NIB_W * base);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      cnt_q  <= '0;
      skip_q <= '0;
    end else if (flush_i) begin
      buf_q  <= '0;
      cnt_q  <= '0;
      skip_q <= flush_nib_i;
    end else begin
      buf_q <= push_i ? (shifted | app) : shifted;
      cnt_q <= push_i ? base + add : base;
      if (push_i) skip_q <= '0;
    end
  end

  assign head_o = buf_q[BUF_BITS-1 -: HEAD_NIB*NIB_W];
  assign cnt_o  = cnt_q;
  assign room_o = cnt_q <= CNT_W'(BUF_NIB - WNIB);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(BUF_NIB)); // R8
  AST_TAKE_AVAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i != 0 |-> CNT_W'(take_i) <= cnt_q); // R7
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> cnt_q == 0); // R9
endmodule

// File: rtl/nibdec_expand.sv
module nibdec_expand
  import nibdec_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic               start_i,
  input  logic [ENTRY_W-1:0] entry_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic               esc_i,
  input  logic [INSTR_W-1:0] esc_word_i,
  output logic               busy_o,
  output logic               valid_o,
  output logic [INSTR_W-1:0] instr_o
);
  localparam int unsigned REST_W = ENTRY_W - INSTR_W;
  logic [REST_W-1:0] ent_q;
  logic [LEN_W-1:0]  rem_q;
  logic              busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
      ent_q  <= '0;
    end else if (flush_i) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
    end else if (start_i && len_i != 0) begin
      busy_q <= 1'b1;
      rem_q  <= len_i;
      ent_q  <= entry_i[REST_W-1:0];
    end else if (busy_q) begin
      ent_q  <= ent_q << INSTR_W;
      rem_q  <= rem_q - 1'b1;
      busy_q <= rem_q > 1;
    end
  end

  always_comb begin
    valid_o = 1'b0;
    instr_o = '0;
    if (busy_q && !flush_i) begin
      valid_o = 1'b1;
      instr_o = ent_q[REST_W-1 -: INSTR_W];
    end else if (start_i) begin
      valid_o = 1'b1;
      instr_o = entry_i[ENTRY_W-1 -: INSTR_W];
    end else if (esc_i) begin
      valid_o = 1'b1;
      instr_o = esc_word_i;
    end
  end

  assign busy_o = busy_q;

  AST_EXPAND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && rem_q > 1 && !flush_i |=> busy_q); // R6
  AST_NO_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !start_i && !esc_i); // R6
endmodule

// File: rtl/nibble_cw_decoder.sv
module nibble_cw_decoder
  import nibdec_pkg::*;
#(
  parameter int unsigned BUF_NIB = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               word_valid_i,
  input  logic [31:0]        word_i,
  output logic               word_ready_o,
  input  logic               redirect_i,
  input  logic [2:0]         redirect_nib_i,
  output logic [13:0]        dict_idx_o,
  output logic               dict_rd_o,
  input  logic [127:0]       dict_entry_i,
  input  logic [1:0]         dict_len_i,
  output logic               instr_valid_o,
  output logic [31:0]        instr_o,
  output logic               consumed_valid_o,
  output logic [3:0]         consumed_o
);
  localparam int unsigned CNT_W = $clog2(BUF_NIB + 1);

  logic [HEAD_NIB*NIB_W-1:0] head;
  logic [CNT_W-1:0]          cnt;
  logic                      room, busy, decode, push;
  item_kind_e                kind;
  logic [3:0]                need, take;
  logic [IDX_W-1:0]          idx;

  nibdec_buffer #(.BUF_NIB(BUF_NIB)) u_buf (
    .clk_i, .rst_ni,
    .push_i(push), .word_i(word_i), .take_i(take),
    .flush_i(redirect_i), .flush_nib_i(redirect_nib_i),
    .head_o(head), .cnt_o(cnt), .room_o(room)
  );

  nibdec_classify u_cls (
    .lead_i(head[HEAD_NIB*NIB_W-1 -: 4*NIB_W]),
    .kind_o(kind), .need_o(need), .idx_o(idx)
  );

  assign decode = !busy && !redirect_i && (cnt >= CNT_W'(need));
  assign take   = decode ? need : 4'd0;
  assign word_ready_o = room && !redirect_i;
  assign push   = word_valid_i && word_ready_o;

  nibdec_expand u_exp (
    .clk_i, .rst_ni,
    .flush_i(redirect_i),
    .start_i(decode && kind != K_ESC),
    .entry_i(dict_entry_i), .len_i(dict_len_i),
    .esc_i(decode && kind == K_ESC),
    .esc_word_i(head[INSTR_W-1:0]),
    .busy_o(busy), .valid_o(instr_valid_o), .instr_o(instr_o)
  );

  assign dict_idx_o       = idx;
  assign dict_rd_o        = decode && kind != K_ESC;
  assign consumed_valid_o = decode;
  assign consumed_o       = take;

  AST_CONSUME_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consumed_valid_o |-> consumed_o inside {4'd2, 4'd3, 4'd4, 4'd9}); // R3
  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dict_rd_o |-> dict_idx_o < 14'(IDX_LIMIT)); // R4
  AST_OUT_WITH_ITEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consumed_valid_o |-> instr_valid_o); // R6
endmodule

// File: tb/nibble_cw_decoder_test.sv
module nibble_cw_decoder_test;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic word_valid_i = 0, redirect_i = 0;
  logic [31:0] word_i = '0;
  logic [2:0] redirect_nib_i = '0;
  logic word_ready_o, dict_rd_o, instr_valid_o, consumed_valid_o;
  logic [13:0] dict_idx_o;
  logic [127:0] dict_entry_i;
  logic [1:0] dict_len_i;
  logic [31:0] instr_o;
  logic [3:0] consumed_o;

  nibble_cw_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .word_valid_i, .word_i, .word_ready_o,
    .redirect_i, .redirect_nib_i, .dict_idx_o, .dict_rd_o, .dict_entry_i,
    .dict_len_i, .instr_valid_o, .instr_o, .consumed_valid_o, .consumed_o
  );

  function automatic logic [31:0] dw(input logic [13:0] i, input int k);
    return {4'hA, 2'(k), i, 12'(i * 7 + k)};
  endfunction
  assign dict_entry_i = {dw(dict_idx_o, 0), dw(dict_idx_o, 1), dw(dict_idx_o, 2), dw(dict_idx_o, 3)};
  assign dict_len_i   = dict_idx_o[1:0];

  int n_chk = 0, n_fail = 0, cyc = 0, cons_seen = 0, instr_seen = 0;
  bit done = 0, saw_stall = 0;
  logic [3:0]  nib_q[$];
  logic [31:0] exp_i[$];
  string       exp_t[$];
  int          exp_c[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (!word_ready_o) saw_stall = 1;
    if (instr_valid_o) begin
      instr_seen++;
      if (exp_i.size() == 0) chk(0, "R7 unexpected instr", instr_o, 0);
      else begin
        logic [31:0] e; string t;
        e = exp_i.pop_front(); t = exp_t.pop_front();
        chk(instr_o == e, t, instr_o, e);
      end
    end
    if (consumed_valid_o) begin
      cons_seen++;
      if (exp_c.size() == 0) chk(0, "R7 unexpected consume", consumed_o, 0);
      else begin
        int c; c = exp_c.pop_front();
        chk(int'(consumed_o) == c, "R3 consumed", consumed_o, c);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  task automatic put(input logic [31:0] v, input int n);
    for (int k = n - 1; k >= 0; k--) nib_q.push_back(v[4*k +: 4]);
  endtask

  task automatic add_cw(input int n, input logic [15:0] c);
    int idx;
    put(32'(c), n);
    if (n == 2) idx = c & 127;
    else if (n == 3) idx = 128 + (c - 16'h800);
    else idx = 1408 + (c - 16'hD000);
    for (int k = 0; k <= idx % 4; k++) begin
      exp_i.push_back(dw(14'(idx), k));
      exp_t.push_back(k == 0 ? "R4 index/first" : "R6 expansion");
    end
    exp_c.push_back(n);
  endtask

  task automatic add_esc(input logic [31:0] v);
    put({28'h0, 4'hF}, 1);
    put(v, 8);
    exp_i.push_back(v); exp_t.push_back("R5 escape");
    exp_c.push_back(9);
  endtask

  task automatic feed_word(input logic [31:0] w);
    bit acc = 0;
    while (!acc) begin
      @(negedge clk);
      word_valid_i = 1; word_i = w;
      acc = word_ready_o;
      @(posedge clk);
    end
  endtask

  task automatic do_redirect(input int skip);
    @(negedge clk);
    word_valid_i = 0; redirect_i = 1; redirect_nib_i = 3'(skip);
    @(negedge clk);
    redirect_i = 0;
  endtask

  task automatic drain(input string tag);
    int t = 0;
    while ((exp_i.size() != 0 || exp_c.size() != 0) && t < 400) begin
      @(negedge clk); t++;
    end
    repeat (4) @(negedge clk);
    chk(exp_i.size() == 0 && exp_c.size() == 0, tag, exp_i.size() + exp_c.size(), 0);
    exp_i.delete(); exp_t.delete(); exp_c.delete();
  endtask

  task automatic run_stream(input int skip, input int gap, input string tag);
    logic [31:0] w;
    do_redirect(skip);
    for (int i = 0; i < skip; i++) nib_q.push_front(4'h0);
    while (nib_q.size() % 8 != 0) nib_q.push_back(4'hF);
    while (nib_q.size() > 0) begin
      w = '0;
      for (int k = 0; k < 8; k++) w = {w[27:0], nib_q.pop_front()};
      feed_word(w);
      if (gap > 0) begin
        @(negedge clk); word_valid_i = 0;
        repeat (gap) @(negedge clk);
      end
    end
    @(negedge clk); word_valid_i = 0;
    drain(tag);
  endtask

  task automatic add_mix();
    add_cw(2, 16'h00);   add_cw(2, 16'h7F);
    add_cw(3, 16'h800);  add_esc(32'h12345678);
    add_cw(3, 16'hCFF);  add_cw(4, 16'hD000);
    add_esc(32'hFFFFFFFF); add_cw(4, 16'hEFFF);
    add_cw(3, 16'h9A5);  add_cw(2, 16'h33);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(!instr_valid_o, "R1 instr_valid", instr_valid_o, 0);
    chk(!consumed_valid_o, "R1 consumed_valid", consumed_valid_o, 0);
    rst_n = 1;
    @(negedge clk);
    chk(word_ready_o, "R1 ready", word_ready_o, 1);
    chk(!instr_valid_o, "R1 idle after reset", instr_valid_o, 0);

    add_mix();
    run_stream(0, 0, "R2 packed mix");

    add_mix();
    run_stream(5, 3, "R7 gapped mix");

    // R7: incomplete escape must stall
    do_redirect(0);
    cons_seen = 0; instr_seen = 0;
    feed_word(32'hF1234567);
    @(negedge clk); word_valid_i = 0;
    repeat (6) @(negedge clk);
    chk(cons_seen == 0 && instr_seen == 0, "R7 stall on partial", cons_seen + instr_seen, 0);
    exp_i.push_back(32'h12345678); exp_t.push_back("R5 escape split"); exp_c.push_back(9);
    feed_word(32'h8FFFFFFF);
    @(negedge clk); word_valid_i = 0;
    drain("R2 split escape");

    // R8: long expansion while words keep arriving
    saw_stall = 0;
    add_cw(4, 16'hD003);
    for (int i = 0; i < 6; i++) add_cw(4, 16'hD003 + 16'(4 * i));
    add_mix();
    run_stream(0, 0, "R8 backpressure data");
    chk(saw_stall, "R8 ready dropped", saw_stall, 1);

    // R9 with random streams and offsets
    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < 25; i++) begin
        case ($urandom_range(0, 3))
          0: add_cw(2, 16'($urandom_range(0, 127)));
          1: add_cw(3, 16'($urandom_range(16'h800, 16'hCFF)));
          2: add_cw(4, 16'($urandom_range(16'hD000, 16'hEFFF)));
          default: add_esc($urandom);
        endcase
      end
      run_stream(int'($urandom_range(0, 7)), r % 2, "R9 random redirect");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule